// File: doc/BRIEF.md
# Effective Address Generator

This block forms the memory address for the load, store and load-address instructions of a 16-bit, word-addressed processor. Each cycle it may accept one request made of the instruction word, the program counter after the fetch increment, and a base value already read from the register file. One clock later it presents a 16-bit address together with flags for the sequencer. The flags say whether the address is final or points to the word that holds the final address, whether a memory access follows, whether that access is a write, and whether the address itself is the value written back to a register.

Three offset forms are supported. A 9-bit signed field in bits [8:0] is added to the incremented program counter. A 6-bit signed field in bits [5:0] is added to a base register. An indirect form builds a pointer address in the same way as the program-counter form. All sums wrap modulo 2^16. An opcode that names no addressing instruction produces no valid result.

Top module: `eag_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ag_valid`, `ag_addr` and every flag output are 0.
- R2: A request on `req_valid` gives its result in the cycle after the clock edge that samples it. A cycle without a request gives `ag_valid` = 0 in the next cycle.
- R3: Opcodes 0010 (load) and 0011 (store) give `ag_addr` = `req_pc` + sign-extended `req_instr[8:0]`, with `ag_ptr` = 0, `ag_mem` = 1 and `ag_wb` = 0.
- R4: Opcodes 0110 (load) and 0111 (store) give `ag_addr` = `req_base` + sign-extended `req_instr[5:0]`, with `ag_ptr` = 0, `ag_mem` = 1 and `ag_wb` = 0.
- R5: Opcodes 1010 (load) and 1011 (store) give `ag_addr` = `req_pc` + sign-extended `req_instr[8:0]`, with `ag_ptr` = 1 and `ag_mem` = 1. In this case the address is the location of a pointer.
- R6: Opcode 1110 gives `ag_addr` = `req_pc` + sign-extended `req_instr[8:0]`, with `ag_wb` = 1 and `ag_mem`, `ag_ptr` and `ag_store` all 0.
- R7: `ag_store` is 1 exactly for opcodes 0011, 0111 and 1011. It is 0 for every other valid result.
- R8: Any other opcode gives `ag_valid` = 0. While `ag_valid` is 0, `ag_addr` and all flags are 0.
- R9: The address sum wraps modulo 2^16. Any carry out of bit 15 is discarded.
- R10: `req_base` has no effect on results for opcodes 0010, 0011, 1010, 1011 and 1110. `req_pc` has no effect on results for opcodes 0110 and 0111. `req_instr[11:9]` has no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_instr | input | 16 | Instruction word; bits [15:12] are the opcode |
| req_pc | input | 16 | Program counter after the fetch increment |
| req_base | input | 16 | Base register value |
| ag_valid | output | 1 | Result valid |
| ag_addr | output | 16 | Effective address, pointer address, or write-back value |
| ag_ptr | output | 1 | The address holds a pointer that must be dereferenced |
| ag_mem | output | 1 | A memory access follows |
| ag_wb | output | 1 | The address is the register write-back value |
| ag_store | output | 1 | The access is a write |

## Verification
Every cycle the block computes both a program-counter sum and a base-register sum, and only one of them may reach the output. The sweep therefore drives PC and base values that always differ, so a selection error changes the address. A new request is also accepted in the same cycle that the previous result is presented. The bench issues requests back to back, with occasional idle cycles between them, and compares each result against an arithmetic model. A result that leaks from a neighbouring request, or a result that survives an idle cycle, shows up as a miscompare.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int AW      = 16;
    localparam int IW      = 16;
    localparam int OPC_W   = 4;
    localparam int PCOFF_W = 9;
    localparam int BOFF_W  = 6;

    localparam logic [OPC_W-1:0] OP_LD  = 4'b0010;
    localparam logic [OPC_W-1:0] OP_ST  = 4'b0011;
    localparam logic [OPC_W-1:0] OP_LDR = 4'b0110;
    localparam logic [OPC_W-1:0] OP_STR = 4'b0111;
    localparam logic [OPC_W-1:0] OP_LDI = 4'b1010;
    localparam logic [OPC_W-1:0] OP_STI = 4'b1011;
    localparam logic [OPC_W-1:0] OP_LEA = 4'b1110;

    typedef struct packed {
        logic ok;
        logic use_base;
        logic ptr;
        logic mem;
        logic wb;
        logic store;
    } ag_ctrl_t;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic          ptr;
        logic          mem;
        logic          wb;
        logic          store;
    } ag_res_t;

    function automatic logic [AW-1:0] sext_pc(input logic [PCOFF_W-1:0] f);
        return {{(AW-PCOFF_W){f[PCOFF_W-1]}}, f};
    endfunction

    function automatic logic [AW-1:0] sext_base(input logic [BOFF_W-1:0] f);
        return {{(AW-BOFF_W){f[BOFF_W-1]}}, f};
    endfunction

endpackage

// File: rtl/eag_decode.sv
module eag_decode
    import eag_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output ag_ctrl_t         ctrl
);
    always_comb begin
        ctrl = '0;
        unique case (opc)
            OP_LD, OP_ST: begin
                ctrl.ok    = 1'b1;
                ctrl.mem   = 1'b1;
                ctrl.store = (opc == OP_ST);
            end
            OP_LDR, OP_STR: begin
                ctrl.ok       = 1'b1;
                ctrl.use_base = 1'b1;
                ctrl.mem      = 1'b1;
                ctrl.store    = (opc == OP_STR);
            end
            OP_LDI, OP_STI: begin
                ctrl.ok    = 1'b1;
                ctrl.ptr   = 1'b1;
                ctrl.mem   = 1'b1;
                ctrl.store = (opc == OP_STI);
            end
            OP_LEA: begin
                ctrl.ok = 1'b1;
                ctrl.wb = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/eag_addgen.sv
module eag_addgen
    import eag_pkg::*;
(
    input  logic [PCOFF_W-1:0] off_field,
    input  logic [AW-1:0]      pc,
    input  logic [AW-1:0]      base,
    input  logic               use_base,
    output logic [AW-1:0]      sum
);
    logic [AW-1:0] pc_sum;
    logic [AW-1:0] base_sum;

    // Both sums are built every cycle; carry out of the top bit is dropped.
    assign pc_sum   = pc + sext_pc(off_field);
    assign base_sum = base + sext_base(off_field[BOFF_W-1:0]);
    assign sum      = use_base ? base_sum : pc_sum;
endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [IW-1:0] req_instr,
    input  logic [AW-1:0] req_pc,
    input  logic [AW-1:0] req_base,
    output logic          ag_valid,
    output logic [AW-1:0] ag_addr,
    output logic          ag_ptr,
    output logic          ag_mem,
    output logic          ag_wb,
    output logic          ag_store
);
    ag_ctrl_t      ctrl;
    logic [AW-1:0] sum;
    ag_res_t       res_q;
    logic          unused_dst;

    assign unused_dst = ^req_instr[IW-OPC_W-1:PCOFF_W];

    eag_decode u_dec (
        .opc  (req_instr[IW-1:IW-OPC_W]),
        .ctrl (ctrl)
    );

    eag_addgen u_add (
        .off_field (req_instr[PCOFF_W-1:0]),
        .pc        (req_pc),
        .base      (req_base),
        .use_base  (ctrl.use_base),
        .sum       (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (req_valid && ctrl.ok) begin
            res_q.valid <= 1'b1;
            res_q.addr  <= sum;
            res_q.ptr   <= ctrl.ptr;
            res_q.mem   <= ctrl.mem;
            res_q.wb    <= ctrl.wb;
            res_q.store <= ctrl.store;
        end else begin
            res_q <= '0;
        end
    end

    assign ag_valid = res_q.valid;
    assign ag_addr  = res_q.addr;
    assign ag_ptr   = res_q.ptr;
    assign ag_mem   = res_q.mem;
    assign ag_wb    = res_q.wb;
    assign ag_store = res_q.store;

    // R2: an idle cycle leaves no result behind
    a_r2_idle_clears: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !ag_valid);

    // R5: a pointer always leads to a memory access
    a_r5_ptr_needs_mem: assert property (@(posedge clk) disable iff (rst)
        ag_ptr |-> ag_mem);

    // R6: an address write-back touches no memory
    a_r6_lea_no_mem: assert property (@(posedge clk) disable iff (rst)
        ag_wb |-> (!ag_mem && !ag_ptr && !ag_store));

    // R7: a write is always a memory access
    a_r7_store_is_mem: assert property (@(posedge clk) disable iff (rst)
        ag_store |-> ag_mem);

    // R8: an invalid result carries no address and no flags
    a_r8_quiet_when_invalid: assert property (@(posedge clk) disable iff (rst)
        !ag_valid |-> (ag_addr == '0 && !ag_ptr && !ag_mem && !ag_wb && !ag_store));

    // R8: every valid result names exactly one action
    a_r8_valid_has_action: assert property (@(posedge clk) disable iff (rst)
        ag_valid |-> $onehot({ag_mem, ag_wb}));
endmodule

// File: tb/eag_top_tb.sv
module eag_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [15:0] req_instr;
    logic [15:0] req_pc;
    logic [15:0] req_base;
    logic        ag_valid;
    logic [15:0] ag_addr;
    logic        ag_ptr, ag_mem, ag_wb, ag_store;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eag_top u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_instr(req_instr),
        .req_pc(req_pc), .req_base(req_base), .ag_valid(ag_valid),
        .ag_addr(ag_addr), .ag_ptr(ag_ptr), .ag_mem(ag_mem), .ag_wb(ag_wb),
        .ag_store(ag_store)
    );

    // expected {valid, addr, ptr, mem, wb, store} and requirement tag
    task automatic model(input logic v, input logic [15:0] ins, input logic [15:0] pc,
                         input logic [15:0] base, output logic [20:0] exp, output string tag);
        logic [15:0] o9, o6;
        o9  = 16'($signed(ins[8:0]));
        o6  = 16'($signed(ins[5:0]));
        exp = '0;
        tag = "R8";
        if (!v) begin
            tag = "R2";
        end else begin
            case (ins[15:12])
                4'b0010: begin exp = {1'b1, 16'(pc + o9), 4'b0100}; tag = "R3"; end
                4'b0011: begin exp = {1'b1, 16'(pc + o9), 4'b0101}; tag = "R3/R7"; end
                4'b0110: begin exp = {1'b1, 16'(base + o6), 4'b0100}; tag = "R4"; end
                4'b0111: begin exp = {1'b1, 16'(base + o6), 4'b0101}; tag = "R4/R7"; end
                4'b1010: begin exp = {1'b1, 16'(pc + o9), 4'b1100}; tag = "R5"; end
                4'b1011: begin exp = {1'b1, 16'(pc + o9), 4'b1101}; tag = "R5/R7"; end
                4'b1110: begin exp = {1'b1, 16'(pc + o9), 4'b0010}; tag = "R6"; end
                default: begin exp = '0; tag = "R8"; end
            endcase
        end
    endtask

    // called at a falling edge: drive, wait one cycle, compare
    task automatic step(input logic v, input logic [15:0] ins, input logic [15:0] pc,
                        input logic [15:0] base, input string extra);
        logic [20:0] exp, act;
        string tag;
        req_valid = v; req_instr = ins; req_pc = pc; req_base = base;
        model(v, ins, pc, base, exp, tag);
        @(negedge clk);
        act = {ag_valid, ag_addr, ag_ptr, ag_mem, ag_wb, ag_store};
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s%s instr=%h pc=%h base=%h actual=%h expected=%h",
                     tag, extra, ins, pc, base, act, exp);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_instr = '0; req_pc = '0; req_base = '0;
        repeat (3) @(negedge clk);
        // R1: reset state, with a decodable request present
        req_valid = 1'b1; req_instr = 16'h2005; req_pc = 16'h1234;
        @(negedge clk);
        vectors++;
        if ({ag_valid, ag_addr, ag_ptr, ag_mem, ag_wb, ag_store} !== 21'd0) begin
            fails++;
            $display("FAIL R1 actual=%h expected=0",
                     {ag_valid, ag_addr, ag_ptr, ag_mem, ag_wb, ag_store});
        end
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        vectors++;
        if ({ag_valid, ag_addr, ag_ptr, ag_mem, ag_wb, ag_store} !== 21'd0) begin
            fails++;
            $display("FAIL R1 first cycle after reset actual=%h expected=0",
                     {ag_valid, ag_addr, ag_ptr, ag_mem, ag_wb, ag_store});
        end

        // R9 corner cases of wrap-around
        step(1'b1, 16'h2001, 16'hFFFF, 16'h0000, " R9");   // LD  FFFF+1 -> 0000
        step(1'b1, 16'h603F, 16'hAAAA, 16'h0000, " R9");   // LDR 0-1 -> FFFF
        step(1'b1, 16'hE100, 16'h0000, 16'h5555, " R9");   // LEA 0-256 -> FF00
        step(1'b1, 16'hB0FF, 16'hFF80, 16'h0000, " R9");   // STI FF80+255 wraps
        step(1'b1, 16'h7020, 16'h0010, 16'h001F, " R9");   // STR 1F-32 wraps

        // Exhaustive sweep: every opcode x every 9-bit field, varied bits [11:9],
        // PC and base always different (R10), back-to-back with idle gaps (R2)
        for (int k = 0; k < 16*512; k++) begin
            logic [15:0] ins, pc, base;
            ins  = {4'(k >> 9), 3'(k * 5), 9'(k)};
            pc   = 16'(k * 16'h9E37 + 16'hFF00);
            base = 16'(pc ^ 16'h8421) | 16'h0001;
            if (base == pc) base = pc + 16'd3;
            step(1'b1, ins, pc, base, " R10");
            if (k % 97 == 0) step(1'b0, ins, pc, base, " idle");
        end

        // R10: same op, different base or upper bits, must not move the PC-relative address
        step(1'b1, 16'h2E10, 16'h4000, 16'h0000, " R10");
        step(1'b1, 16'h2010, 16'h4000, 16'hFFFF, " R10");
        step(1'b1, 16'h6C01, 16'h0000, 16'h3000, " R10");
        step(1'b1, 16'h6001, 16'hFFFF, 16'h3000, " R10");
        step(1'b0, 16'hE001, 16'h1000, 16'h0000, " R2");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule